// File: doc/BRIEF.md
# Token-Ring Depth-Chained FIFO

A deeper synchronous FIFO built from a ring of identical storage slices. Each slice has its own memory, its own write and read pointers and its own fill counter. Two tokens travel around the ring: one marks the slice that takes the next write, the other marks the slice that supplies the next read. A slice that writes its last physical location hands the write token to its successor in the same cycle. A slice that reads its last physical location hands the read token on in the same way. The last slice feeds the first.

One strap bit per slice selects the slice that starts with both tokens after reset; exactly one strap bit is driven low. Write data fans out to every slice. The read data comes from the slice that holds the read token, with show-ahead timing: the oldest stored word is present on the output before the read strobe. The composite full and empty flags are formed from the active-low flags of all slices. Retransmit and half-full indication do not exist in this chained mode.

Top module: `depth_chain_fifo`

## Requirements
- R1: During reset and in the first cycle after reset, empty_o is 1 and full_o is 0. The slice whose strap bit is 0 holds both the write token and the read token.
- R2: At every cycle out of reset, exactly one slice holds the write token and exactly one slice holds the read token.
- R3: Words leave in the order they were accepted, including across slice boundaries and across the wrap from the last slice to the first.
- R4: full_o is 1 exactly when the stored count equals N_SLICES*SLICE_DEPTH. A write strobe alone while full is ignored, and the contents and the flags stay unchanged.
- R5: empty_o is 1 exactly when the stored count is zero. A read strobe while empty is ignored.
- R6: A write to the last location of a slice passes the write token to the next slice (ring order, last to first) in time for the write in the next cycle. The read token is passed in the same way.
- R7: A read and a write in the same cycle both take effect, except that a write is rejected while full and a read is rejected while empty. The flags are sampled before the edge.
- R8: Whenever empty_o is 0, rd_data_o shows the oldest stored word (show-ahead).
- R9: Any single slice may be strapped first. The FIFO behaviour seen at the ports does not depend on which slice it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| first_load_ni | input | N_SLICES | Strap per slice; the bit that is 0 marks the starting slice |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | WIDTH | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | WIDTH | Oldest stored word (show-ahead) |
| full_o | output | 1 | Composite full |
| empty_o | output | 1 | Composite empty |

## Verification
On every cycle, the assertions check that each token is unique, that each token handoff lands on the successor slice, that the two flags are never both set, and that the flags stay put under strobes the FIFO must ignore. Data order across slice boundaries, the show-ahead output, the exact count at which full appears and the independence from the strap choice are visible only to the bench's scenarios. These compare every output against a reference queue while the fill level sweeps from empty to full and back.

// File: rtl/chain_fifo_pkg.sv
package chain_fifo_pkg;
  typedef struct packed {
    logic wr_tok;
    logic rd_tok;
    logic empty_n;
    logic full_n;
  } slice_stat_t;
endpackage

// File: rtl/exp_token.sv
module exp_token (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic xi_i,
  input  logic used_last_i,
  output logic tok_o
);
  logic tok_q;

  // incoming handoff wins so a single-slice ring keeps its token
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tok_q <= start_i;
    else if (xi_i)        tok_q <= 1'b1;
    else if (used_last_i) tok_q <= 1'b0;
  end

  assign tok_o = tok_q;
endmodule

// File: rtl/slice_store.sv
module slice_store #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_fire_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_fire_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             wr_last_o,
  output logic             rd_last_o,
  output logic             empty_no,
  output logic             full_no
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk_i) begin
    if (wr_fire_i) mem[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_fire_i) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (rd_fire_i) rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({wr_fire_i, rd_fire_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_data_o = mem[rd_ptr_q];
  assign wr_last_o = (wr_ptr_q == LAST);
  assign rd_last_o = (rd_ptr_q == LAST);
  assign empty_no  = (cnt_q != '0);
  assign full_no   = (cnt_q != CW'(DEPTH));
endmodule

// File: rtl/fifo_slice.sv
module fifo_slice
  import chain_fifo_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             first_load_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic             xi_wr_i,
  input  logic             xi_rd_i,
  output logic             xo_wr_o,
  output logic             xo_rd_o,
  output logic [WIDTH-1:0] rd_data_o,
  output slice_stat_t      stat_o
);
  logic wr_tok, rd_tok, wr_fire, rd_fire;
  logic wr_last, rd_last, empty_n, full_n;

  assign wr_fire = wr_en_i & wr_tok & full_n;
  assign rd_fire = rd_en_i & rd_tok & empty_n;
  assign xo_wr_o = wr_fire & wr_last;
  assign xo_rd_o = rd_fire & rd_last;

  exp_token i_wr_tok (
    .clk_i, .rst_ni, .start_i(~first_load_ni),
    .xi_i(xi_wr_i), .used_last_i(xo_wr_o), .tok_o(wr_tok)
  );

  exp_token i_rd_tok (
    .clk_i, .rst_ni, .start_i(~first_load_ni),
    .xi_i(xi_rd_i), .used_last_i(xo_rd_o), .tok_o(rd_tok)
  );

  slice_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_store (
    .clk_i, .rst_ni,
    .wr_fire_i(wr_fire), .wr_data_i,
    .rd_fire_i(rd_fire), .rd_data_o,
    .wr_last_o(wr_last), .rd_last_o(rd_last),
    .empty_no(empty_n), .full_no(full_n)
  );

  assign stat_o = '{wr_tok: wr_tok, rd_tok: rd_tok, empty_n: empty_n, full_n: full_n};
endmodule

// File: rtl/depth_chain_fifo.sv
module depth_chain_fifo
  import chain_fifo_pkg::*;
#(
  parameter int WIDTH       = 9,
  parameter int SLICE_DEPTH = 16,
  parameter int N_SLICES    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_SLICES-1:0] first_load_ni,
  input  logic                wr_en_i,
  input  logic [WIDTH-1:0]    wr_data_i,
  input  logic                rd_en_i,
  output logic [WIDTH-1:0]    rd_data_o,
  output logic                full_o,
  output logic                empty_o
);
  slice_stat_t         stat    [N_SLICES];
  logic [WIDTH-1:0]    sl_data [N_SLICES];
  logic [N_SLICES-1:0] xo_wr_vec, xo_rd_vec;
  logic [N_SLICES-1:0] wr_tok_vec, rd_tok_vec, empty_n_vec, full_n_vec;

  for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
    localparam int PREV = (i + N_SLICES - 1) % N_SLICES;
    fifo_slice #(.WIDTH(WIDTH), .DEPTH(SLICE_DEPTH)) i_slice (
      .clk_i, .rst_ni,
      .first_load_ni(first_load_ni[i]),
      .wr_en_i, .wr_data_i, .rd_en_i,
      .xi_wr_i(xo_wr_vec[PREV]),
      .xi_rd_i(xo_rd_vec[PREV]),
      .xo_wr_o(xo_wr_vec[i]),
      .xo_rd_o(xo_rd_vec[i]),
      .rd_data_o(sl_data[i]),
      .stat_o(stat[i])
    );
    assign wr_tok_vec[i]  = stat[i].wr_tok;
    assign rd_tok_vec[i]  = stat[i].rd_tok;
    assign empty_n_vec[i] = stat[i].empty_n;
    assign full_n_vec[i]  = stat[i].full_n;
  end

  // read-token owner drives the shared output
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N_SLICES; i++) begin
      if (rd_tok_vec[i]) rd_data_o = rd_data_o | sl_data[i];
    end
  end

  assign full_o  = ~|full_n_vec;
  assign empty_o = ~|empty_n_vec;
endmodule

// File: rtl/depth_chain_fifo_chk.sv
module depth_chain_fifo_chk #(
  parameter int N_SLICES = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic                rd_en_i,
  input logic                full_o,
  input logic                empty_o,
  input logic [N_SLICES-1:0] wr_tok_vec,
  input logic [N_SLICES-1:0] rd_tok_vec,
  input logic [N_SLICES-1:0] xo_wr_vec,
  input logic [N_SLICES-1:0] xo_rd_vec
);
  AST_WR_TOK_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni) $countones(wr_tok_vec) == 1); // R2
  AST_RD_TOK_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni) $countones(rd_tok_vec) == 1); // R2
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni) !(full_o && empty_o)); // R4
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni) full_o && !rd_en_i |=> full_o); // R4
  AST_EMPTY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni) empty_o && !wr_en_i |=> empty_o); // R5
  AST_FULL_READ_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni) full_o && rd_en_i |=> !full_o); // R7
  AST_EMPTY_WRITE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni) empty_o && wr_en_i |=> !empty_o); // R7

  for (genvar i = 0; i < N_SLICES; i++) begin : g_handoff
    localparam int NXT = (i + 1) % N_SLICES;
    AST_WR_HANDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni) xo_wr_vec[i] |=> wr_tok_vec[NXT]); // R6
    AST_RD_HANDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni) xo_rd_vec[i] |=> rd_tok_vec[NXT]); // R6
  end
endmodule

bind depth_chain_fifo depth_chain_fifo_chk #(.N_SLICES(N_SLICES)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .full_o(full_o), .empty_o(empty_o),
  .wr_tok_vec(wr_tok_vec), .rd_tok_vec(rd_tok_vec),
  .xo_wr_vec(xo_wr_vec), .xo_rd_vec(xo_rd_vec)
);

// File: tb/test_depth_chain_fifo.sv
`timescale 1ns/1ps
module test_depth_chain_fifo;
  localparam int W   = 9;
  localparam int D   = 16;
  localparam int N   = 3;
  localparam int CAP = N * D;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] first_load_ni = 3'b110;
  logic         wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic [W-1:0] rd_data_o;
  logic         full_o, empty_o;

  int  errors = 0, checks = 0;
  bit  done = 0;
  int  q[$];

  always #2 clk = ~clk;

  depth_chain_fifo #(.WIDTH(W), .SLICE_DEPTH(D), .N_SLICES(N)) i_depth_chain_fifo (
    .clk_i(clk), .rst_ni, .first_load_ni, .wr_en_i, .wr_data_i,
    .rd_en_i, .rd_data_o, .full_o, .empty_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_full();
    return q.size() == CAP;
  endfunction

  function automatic bit exp_empty();
    return q.size() == 0;
  endfunction

  task automatic check_outputs(input string tag);
    chk(empty_o === exp_empty(), "R5", int'(empty_o), int'(exp_empty()));
    chk(full_o === exp_full(), "R4", int'(full_o), int'(exp_full()));
    if (q.size() > 0)
      chk(rd_data_o === W'(q[0]), tag, int'(rd_data_o), q[0]);
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input bit w, input bit r, input string tag);
    bit wr_ok, rd_ok;
    logic [W-1:0] d;
    check_outputs(tag);
    d = W'($urandom);
    wr_en_i = w; rd_en_i = r; wr_data_i = d;
    wr_ok = w && !exp_full();
    rd_ok = r && !exp_empty();
    @(posedge clk);
    if (rd_ok) void'(q.pop_front());
    if (wr_ok) q.push_back(int'(d));
    @(negedge clk);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
  endtask

  task automatic do_reset(input logic [N-1:0] strap);
    rst_ni = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0; first_load_ni = strap;
    q.delete();
    repeat (3) @(negedge clk);
    chk(empty_o === 1'b1, "R1", int'(empty_o), 1);
    chk(full_o === 1'b0, "R1", int'(full_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(empty_o === 1'b1, "R1", int'(empty_o), 1);
    chk(full_o === 1'b0, "R1", int'(full_o), 0);
  endtask

  task automatic random_phase(input int cycles, input int pw, input int pr, input string tag);
    for (int k = 0; k < cycles; k++)
      step(($urandom % 100) < pw, ($urandom % 100) < pr, tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    @(negedge clk);
    do_reset(3'b110);
    step(0, 1, "R5");
    step(0, 1, "R5");
    step(1, 1, "R7");                     // write taken, read refused while empty
    for (int k = 0; k < CAP; k++) step(1, 0, "R6"); // fill across both boundaries
    step(1, 0, "R4");                     // ignored while full
    step(1, 0, "R4");
    step(1, 1, "R7");                     // read taken, write refused while full
    for (int k = 0; k < CAP + 3; k++) step(0, 1, "R3");
    for (int k = 0; k < D + 2; k++) step(1, 0, "R6");
    for (int k = 0; k < D + 2; k++) step(1, 1, "R8");
    random_phase(1500, 70, 40, "R3");
    random_phase(1500, 50, 50, "R2");
    random_phase(1500, 35, 70, "R8");
    do_reset(3'b011);                     // slice 2 strapped first
    for (int k = 0; k < CAP + 1; k++) step(1, 0, "R9");
    step(1, 1, "R9");
    for (int k = 0; k < CAP + 1; k++) step(0, 1, "R9");
    random_phase(2000, 55, 50, "R9");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R3 act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule